// File: doc/BRIEF.md
# Latched Fault Alert Controller

This block drives the active-low alert line of a power-supply management interface. It watches a vector of status and fault conditions. A condition that appears, or any change in a condition bit, pulls the alert low. The alert then stays low until the host clears it. Next to the alert line the block keeps a sticky status vector that the host's register logic can read. It shows every condition that was active or changed since the last clear.

There are two ways to clear the alert. The first is a one-cycle clear-faults strobe. The second is a recycle of the main output: the output is switched off and then on again. The off-then-on sequence is watched separately on each enable source, such as a remote on/off pin and a software operation control. A clear event releases the line and empties the status vector. If a condition is still active, the alert drops again on the next cycle and the status reloads. The host therefore can never clear away a live fault.

Top module: `fault_alert_ctrl`

## Requirements
- R1: While in reset and after it, `alert_no` is high and `status_o` is all zeros until a condition becomes active.
- R2: A condition bit that becomes active, or changes in either direction, drives `alert_no` low at the second rising clock edge after the input change. `alert_no` stays high at the first edge.
- R3: Once low, `alert_no` stays low when all conditions go away, until a clear event occurs.
- R4: Status bit i is set when condition i is active or changes. Bits from different conditions accumulate by OR, and each bit holds until a clear event.
- R5: A clear event at a clock edge sets `alert_no` high and `status_o` to zero at that edge. A clear event is `clear_i` high, or a recycle as defined in R7.
- R6: If a condition is still active at a clear event, `alert_no` goes low again and `status_o` reloads with the active bits at the next clock edge.
- R7: A recycle happens when bit k of `out_en_i` falls and then, some later cycle, rises. The resulting clear event takes effect at the second rising edge after the rise is driven.
- R8: A rise of an enable bit with no earlier fall does not release the alert. A fall alone does not release the alert either.
- R9: Condition bit positions are fixed as follows:
  - 0: input undervoltage
  - 1: input overvoltage
  - 2: output undervoltage
  - 3: output overvoltage
  - 4: output overcurrent
  - 5: temperature warning
  - 6: temperature fault
  - 7: fan failure
  - 8: communication error
  - 9: packet checksum error
  - 10: unsupported command or bad data
  - 11: internal fault

  The unsupported command bit asserts the alert and sets status bit 10 in the same way as any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | N_COND | Condition inputs, one bit per monitored source |
| clear_i | input | 1 | Clear-faults strobe, one cycle |
| out_en_i | input | N_EN | Main-output enable sources, watched for off-then-on recycle |
| alert_no | output | 1 | Alert line, active low, latched |
| status_o | output | N_COND | Sticky status vector |

## Verification
A wrong internal state can show at the ports in a few ways:
- A lost latch bit shows as `alert_no` returning high while the status is still nonzero, or within one cycle after a condition disappears.
- A lost reload shows as the line staying high on the cycle after a clear while a condition persists.
- A wrongly armed recycle detector shows up only when the enable next rises: the alert releases without a prior fall.

The opposite fault, a detector that never arms, keeps the alert low past the second edge after a genuine off-then-on sequence. Every such error is visible within two clock edges of the stimulus that exposes it.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned N_SRC = 12;
  localparam int unsigned N_ENS = 2;

  localparam int unsigned CI_VIN_UV    = 0;
  localparam int unsigned CI_VIN_OV    = 1;
  localparam int unsigned CI_VOUT_UV   = 2;
  localparam int unsigned CI_VOUT_OV   = 3;
  localparam int unsigned CI_IOUT_OC   = 4;
  localparam int unsigned CI_TEMP_WARN = 5;
  localparam int unsigned CI_TEMP_FLT  = 6;
  localparam int unsigned CI_FAN_FAIL  = 7;
  localparam int unsigned CI_COMM_ERR  = 8;
  localparam int unsigned CI_CKSUM_ERR = 9;
  localparam int unsigned CI_BAD_CMD   = 10;
  localparam int unsigned CI_INTERNAL  = 11;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'b00,
    RC_ARMED = 2'b01
  } rc_state_e;
endpackage

// File: rtl/fa_change_det.sv
module fa_change_det #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] cond_q_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] cond_q, cond_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      cond_p <= '0;
    end else begin
      cond_q <= cond_i;
      cond_p <= cond_q;
    end
  end

  assign cond_q_o = cond_q;
  assign chg_o    = cond_q ^ cond_p;
endmodule

// File: rtl/fa_recycle_det.sv
module fa_recycle_det
  import fa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic recycle_o
);
  logic      en_q, en_p;
  rc_state_e state_q, state_d;
  logic      fall, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      en_p <= 1'b0;
    end else begin
      en_q <= en_i;
      en_p <= en_q;
    end
  end

  assign fall = en_p & ~en_q;
  assign rise = ~en_p & en_q;

  always_comb begin
    state_d   = state_q;
    recycle_o = 1'b0;
    unique case (state_q)
      RC_IDLE:  if (fall) state_d = RC_ARMED;
      RC_ARMED: if (rise) begin
        recycle_o = 1'b1;
        state_d   = RC_IDLE;
      end
      default:  state_d = RC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RC_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/fa_sticky_latch.sv
module fa_sticky_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_q_i,
  input  logic [W-1:0] chg_i,
  input  logic         clr_i,
  output logic         alert_no,
  output logic [W-1:0] status_o
);
  logic [W-1:0] sticky_q;
  logic         alert_q;
  logic [W-1:0] hit;

  assign hit = cond_q_i | chg_i;

  // clear wins; active bits reload on the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      alert_q  <= 1'b0;
    end else if (clr_i) begin
      sticky_q <= '0;
      alert_q  <= 1'b0;
    end else begin
      sticky_q <= sticky_q | hit;
      alert_q  <= alert_q | (|hit);
    end
  end

  assign alert_no = ~alert_q;
  assign status_o = sticky_q;
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fa_pkg::*;
#(
  parameter int unsigned N_COND = N_SRC,
  parameter int unsigned N_EN   = N_ENS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_COND-1:0] cond_i,
  input  logic              clear_i,
  input  logic [N_EN-1:0]   out_en_i,
  output logic              alert_no,
  output logic [N_COND-1:0] status_o
);
  logic [N_COND-1:0] cond_q, chg;
  logic [N_EN-1:0]   recycle;
  logic              clr_evt;

  fa_change_det #(.W(N_COND)) u_chg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_i  (cond_i),
    .cond_q_o(cond_q),
    .chg_o   (chg)
  );

  for (genvar k = 0; k < N_EN; k++) begin : g_rc
    fa_recycle_det u_rc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (out_en_i[k]),
      .recycle_o(recycle[k])
    );
  end

  assign clr_evt = clear_i | (|recycle);

  fa_sticky_latch #(.W(N_COND)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cond_q_i(cond_q),
    .chg_i   (chg),
    .clr_i   (clr_evt),
    .alert_no(alert_no),
    .status_o(status_o)
  );
endmodule

// File: rtl/fault_alert_ctrl_chk.sv
module fault_alert_ctrl_chk #(
  parameter int unsigned N_COND = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              clr_evt,
  input logic [N_COND-1:0] cond_q,
  input logic              alert_no,
  input logic [N_COND-1:0] status_o
);
  p_clr_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> alert_no);

  p_clr_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_evt |=> (status_o == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_no && !clr_evt) |=> !alert_no);

  p_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cond_q) && !clr_evt) |=> !alert_no);

  p_sticky_mono_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_evt |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

bind fault_alert_ctrl fault_alert_ctrl_chk #(.N_COND(N_COND)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clear_i (clear_i),
  .clr_evt (clr_evt),
  .cond_q  (cond_q),
  .alert_no(alert_no),
  .status_o(status_o)
);

// File: tb/sim_fault_alert_ctrl.sv
`timescale 1ns/1ps
module sim_fault_alert_ctrl;
  import fa_pkg::*;
  localparam int unsigned NC = N_SRC;
  localparam int unsigned NE = N_ENS;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] cond_i = '0;
  logic          clear_i = 1'b0;
  logic [NE-1:0] out_en_i = '0;
  logic          alert_no;
  logic [NC-1:0] status_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fault_alert_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .clear_i(clear_i),
    .out_en_i(out_en_i), .alert_no(alert_no), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #1;
  endtask

  task automatic drive_cond(input logic [NC-1:0] v);
    @(negedge clk_i); cond_i = v;
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1'b1;
    edges(1);
    @(negedge clk_i); clear_i = 1'b0;
  endtask

  task automatic latch_blip(input int unsigned bitn);
    drive_cond(NC'(1) << bitn); edges(2);
    drive_cond('0); edges(2);
  endtask

  task automatic t_reset();
    chk("R1 alert idle", 32'(alert_no), 32'd1);
    chk("R1 status empty", 32'(status_o), 32'd0);
    edges(3);
    chk("R1 alert idle later", 32'(alert_no), 32'd1);
  endtask

  task automatic t_set_latch();
    drive_cond(NC'(1) << CI_IOUT_OC);
    edges(1);
    chk("R2 alert not yet at first edge", 32'(alert_no), 32'd1);
    edges(1);
    chk("R2 alert low at second edge", 32'(alert_no), 32'd0);
    chk("R4 status overcurrent", 32'(status_o), 32'(1 << CI_IOUT_OC));
    drive_cond('0); edges(3);
    chk("R3 alert latched after removal", 32'(alert_no), 32'd0);
    chk("R3 status kept", 32'(status_o), 32'(1 << CI_IOUT_OC));
    pulse_clear();
    chk("R5 alert released", 32'(alert_no), 32'd1);
    chk("R5 status cleared", 32'(status_o), 32'd0);
    edges(2);
    chk("R5 alert stays released", 32'(alert_no), 32'd1);
  endtask

  task automatic t_reassert();
    drive_cond(NC'(1) << CI_FAN_FAIL); edges(2);
    chk("R2 fan alert", 32'(alert_no), 32'd0);
    @(negedge clk_i); clear_i = 1'b1;
    edges(1);
    chk("R5 released at clear edge", 32'(alert_no), 32'd1);
    chk("R5 status zero at clear edge", 32'(status_o), 32'd0);
    @(negedge clk_i); clear_i = 1'b0;
    edges(1);
    chk("R6 alert reasserts", 32'(alert_no), 32'd0);
    chk("R6 status reloads", 32'(status_o), 32'(1 << CI_FAN_FAIL));
    drive_cond('0); edges(2);
    pulse_clear(); edges(2);
    chk("R6 no reassert once gone", 32'(alert_no), 32'd1);
  endtask

  task automatic t_accum();
    drive_cond(NC'(1) << CI_VIN_UV); edges(2);
    drive_cond((NC'(1) << CI_VIN_UV) | (NC'(1) << CI_CKSUM_ERR)); edges(2);
    chk("R4 OR accumulation", 32'(status_o), 32'((1 << CI_VIN_UV) | (1 << CI_CKSUM_ERR)));
    drive_cond(NC'(1) << CI_CKSUM_ERR); edges(2);
    chk("R4 bit held after drop", 32'(status_o), 32'((1 << CI_VIN_UV) | (1 << CI_CKSUM_ERR)));
    drive_cond('0); edges(2);
    pulse_clear(); edges(1);
    chk("R4 cleared together", 32'(status_o), 32'd0);
  endtask

  task automatic t_bad_cmd();
    drive_cond(NC'(1) << CI_BAD_CMD); edges(2);
    chk("R9 bad command alert", 32'(alert_no), 32'd0);
    chk("R9 bad command bit 10", 32'(status_o), 32'(1 << 10));
    drive_cond('0); edges(2);
    pulse_clear();
    chk("R9 cleared", 32'(alert_no), 32'd1);
  endtask

  task automatic t_rise_only();
    latch_blip(CI_VOUT_OV);
    @(negedge clk_i); out_en_i[0] = 1'b1;
    edges(3);
    chk("R8 rise alone keeps alert (en0)", 32'(alert_no), 32'd0);
    @(negedge clk_i); out_en_i[1] = 1'b1;
    edges(3);
    chk("R8 rise alone keeps alert (en1)", 32'(alert_no), 32'd0);
  endtask

  task automatic t_recycle(input int unsigned k);
    @(negedge clk_i); out_en_i[k] = 1'b0;
    edges(4);
    chk("R8 fall alone keeps alert", 32'(alert_no), 32'd0);
    @(negedge clk_i); out_en_i[k] = 1'b1;
    edges(1);
    chk("R7 not released at first edge after rise", 32'(alert_no), 32'd0);
    edges(1);
    chk("R7 released by recycle", 32'(alert_no), 32'd1);
    chk("R7 status cleared by recycle", 32'(status_o), 32'd0);
  endtask

  initial begin
    edges(3);
    @(negedge clk_i); rst_ni = 1'b1;
    edges(1);
    t_reset();
    t_set_latch();
    t_reassert();
    t_accum();
    t_bad_cmd();
    t_rise_only();
    t_recycle(0);
    latch_blip(CI_TEMP_WARN);
    t_recycle(1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule